// File: doc/BRIEF.md
# Byte-Lane Bus Parity Generator and Checker

This block sits between a processor core and a 64-bit external data bus and handles even parity for each of the eight byte lanes. During a write cycle it registers the core's write data, forms one parity bit per byte, and drives data and parity together onto the bus. The bus drive enable comes up from the second clock of the write cycle onward.

During a read cycle it samples the bus data and the incoming parity only on a clock where the ready strobe is high. It recomputes the parity of every byte and compares it with the received bits. Only lanes whose byte enable is high take part in the comparison. Any mismatch on an enabled lane raises a registered parity-check flag for one clock.

Top module: `lane_parity_unit`

## Requirements
- R1: While `rst_n` is low, every register clears at the clock edge: `par_err`, `bus_oe`, `rd_strobe`, `bus_dout`, `bus_pout` and `rd_data` are all zero after that edge.
- R2: Bit n of `bus_pout` makes byte lane n of `bus_dout` (bits 8n+7..8n) plus that bit hold an even number of ones. Bit 7 covers bits 63..56 and bit 0 covers bits 7..0.
- R3: `bus_oe` is low during the first clock of a write cycle (`wr_cycle` high). It is high from the second clock onward while `wr_cycle` stays high, and goes low one clock after `wr_cycle` falls.
- R4: On every clock with `wr_cycle` high, `bus_dout` and `bus_pout` take the write data from that clock and its parity. Both are valid one clock later, in the same cycle, so data and parity always change together.
- R5: A read sample happens only on a clock with `rd_cycle` high, `rdy` high and `wr_cycle` low. On such a clock `rd_data` takes `bus_din` and `rd_strobe` pulses high one clock later. On any other clock `rd_data` holds its value and `rd_strobe` is low.
- R6: When a read sample finds a parity mismatch, `par_err` is high for exactly the one clock after that sample. It is low again afterwards unless the next clock is also a failing sample.
- R7: A lane whose `byte_en` bit is low never causes `par_err`, whatever its data and parity. With `byte_en` all zero, no sample can flag.
- R8: `par_err` stays low on clocks that are not read samples. This covers `rdy` low, idle, write cycles, and clocks where `rd_cycle` and `wr_cycle` are both high, even when the bus carries bad parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_cycle | input | 1 | High for every clock of a write cycle |
| rd_cycle | input | 1 | High for every clock of a read cycle |
| rdy | input | 1 | Ready strobe qualifying read data |
| byte_en | input | 8 | Active-high byte-lane valid marks for the read check |
| core_wdata | input | 64 | Write data from the core |
| bus_din | input | 64 | Data arriving from the bus |
| bus_pin | input | 8 | Parity arriving from the bus, bit n for lane n |
| bus_dout | output | 64 | Registered data driven to the bus |
| bus_pout | output | 8 | Registered even parity driven with `bus_dout` |
| bus_oe | output | 1 | Drive enable for data and parity |
| rd_data | output | 64 | Last sampled read data |
| rd_strobe | output | 1 | One-clock pulse after a read sample |
| par_err | output | 1 | Registered parity-check flag |

## Verification
Every result in this block is due exactly one rising edge after its stimulus. This applies to the write data, the parity and the drive enable, and also to the captured read data, the read strobe and the check flag. The only exception is the first-clock low of the drive enable, which is seen before that edge.

The bench applies inputs on the falling edge and compares on the next falling edge, so exactly one register stage lies between them. The one-clock width of the flag is checked by idling for a further clock and confirming that the flag has returned low.

// File: rtl/lane_parity_pkg.sv
// Package: shared sizing for the byte-lane parity unit.
// Assumes the data width is a whole number of lanes.
package lane_parity_pkg;
    localparam int unsigned BUS_W  = 64;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned N_LANE = BUS_W / LANE_W;
endpackage

// File: rtl/lane_parity_gen.sv
// lane_parity_gen: combinational even-parity former, one bit per lane.
// Assumes DATA_W is a multiple of LANE_W; bit n covers lane n.
module lane_parity_gen #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [LANES-1:0]  par_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Reduction XOR of one lane gives the bit that makes the lane even.
        assign par_o[g] = ^data_i[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/wr_drive_stage.sv
// wr_drive_stage: registers write data and its parity and raises the drive
// enable from the second clock of a write cycle. Assumes wr_cycle is held
// high for the whole write cycle.
module wr_drive_stage #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cycle,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LANES-1:0]  wpar_i,
    output logic [DATA_W-1:0] dout_o,
    output logic [LANES-1:0]  pout_o,
    output logic              oe_o
);
    // Capture data and parity together on each write-cycle clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_o <= '0;
            pout_o <= '0;
        end else if (wr_cycle) begin
            dout_o <= wdata_i;
            pout_o <= wpar_i;
        end
    end

    // Drive enable trails the cycle indication by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_o <= 1'b0;
        else        oe_o <= wr_cycle;
    end
endmodule

// File: rtl/rd_check_stage.sv
// rd_check_stage: samples read data on ready-qualified clocks and flags any
// enabled lane whose received parity differs from the recomputed one.
// Assumes calc_par_i is the parity of din_i formed in the same cycle.
module rd_check_stage #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cycle,
    input  logic              wr_cycle,
    input  logic              rdy,
    input  logic [LANES-1:0]  lane_en_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic [LANES-1:0]  pin_i,
    input  logic [LANES-1:0]  calc_par_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              strobe_o,
    output logic              err_o
);
    logic             sample;
    logic [LANES-1:0] lane_bad;

    // Qualify the sample and mask mismatching lanes with the byte enables.
    always_comb begin
        sample   = rd_cycle && rdy && !wr_cycle;
        lane_bad = (calc_par_i ^ pin_i) & lane_en_i;
    end

    // Hold read data between samples.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_o <= '0;
        else if (sample) rdata_o <= din_i;
    end

    // One-clock strobe and error flag for each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_o <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            strobe_o <= sample;
            err_o    <= sample && (|lane_bad);
        end
    end
endmodule

// File: rtl/lane_parity_unit.sv
// lane_parity_unit: byte-lane even parity for a bus in both directions.
// Writes: registered data plus parity, driven from the second clock.
// Reads: masked parity check on ready-qualified samples, registered flag.
// Assumes rd_cycle and wr_cycle come from the same clock domain.
module lane_parity_unit
    import lane_parity_pkg::*;
#(
    parameter int unsigned DATA_W = BUS_W,
    parameter int unsigned BYTE_W = LANE_W,
    localparam int unsigned NL = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cycle,
    input  logic              rd_cycle,
    input  logic              rdy,
    input  logic [NL-1:0]     byte_en,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [NL-1:0]     bus_pin,
    output logic [DATA_W-1:0] bus_dout,
    output logic [NL-1:0]     bus_pout,
    output logic              bus_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_strobe,
    output logic              par_err
);
    logic [NL-1:0] wr_par;
    logic [NL-1:0] rd_par;

    lane_parity_gen #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_wgen (
        .data_i(core_wdata), .par_o(wr_par)
    );

    lane_parity_gen #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_rgen (
        .data_i(bus_din), .par_o(rd_par)
    );

    wr_drive_stage #(.DATA_W(DATA_W), .LANES(NL)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_cycle(wr_cycle),
        .wdata_i(core_wdata), .wpar_i(wr_par),
        .dout_o(bus_dout), .pout_o(bus_pout), .oe_o(bus_oe)
    );

    rd_check_stage #(.DATA_W(DATA_W), .LANES(NL)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_cycle(rd_cycle), .wr_cycle(wr_cycle),
        .rdy(rdy), .lane_en_i(byte_en), .din_i(bus_din), .pin_i(bus_pin),
        .calc_par_i(rd_par), .rdata_o(rd_data), .strobe_o(rd_strobe),
        .err_o(par_err)
    );
endmodule

// File: rtl/lane_parity_unit_chk.sv
// lane_parity_unit_chk: temporal checks on the parity unit's ports.
module lane_parity_unit_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned NL     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_cycle,
    input logic              rd_cycle,
    input logic              rdy,
    input logic [NL-1:0]     byte_en,
    input logic [DATA_W-1:0] bus_dout,
    input logic [NL-1:0]     bus_pout,
    input logic              bus_oe,
    input logic              rd_strobe,
    input logic              par_err
);
    localparam int unsigned BW = DATA_W / NL;

    // True when every lane plus its parity bit holds an even count of ones.
    function automatic logic lanes_even(input logic [DATA_W-1:0] d,
                                        input logic [NL-1:0] p);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NL; i++)
            if ((^d[i*BW +: BW]) ^ p[i]) ok = 1'b0;
        return ok;
    endfunction

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!par_err && !bus_oe && !rd_strobe));

    p_even_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> lanes_even(bus_dout, bus_pout));

    p_first_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_cycle) |-> !bus_oe);

    p_later_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cycle |=> bus_oe);

    p_strobe_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> $past(rd_cycle && rdy && !wr_cycle));

    p_err_with_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> rd_strobe);

    p_no_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cycle && rdy && !wr_cycle && byte_en == '0) |=> !par_err);

    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_cycle || !rdy || wr_cycle) |=> !par_err);
endmodule

bind lane_parity_unit lane_parity_unit_chk #(.DATA_W(DATA_W), .NL(NL)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_cycle(wr_cycle), .rd_cycle(rd_cycle),
    .rdy(rdy), .byte_en(byte_en), .bus_dout(bus_dout), .bus_pout(bus_pout),
    .bus_oe(bus_oe), .rd_strobe(rd_strobe), .par_err(par_err)
);

// File: tb/lane_parity_unit_test.sv
module lane_parity_unit_test;
    localparam int CLK_P = 10;
    localparam int NV    = 10;

    // Read vectors: data, lanes to corrupt, byte enables, ready.
    localparam logic [63:0] T_DATA [NV] = '{
        64'h0000_0000_0000_0000, 64'h0123_4567_89AB_CDEF,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001,
        64'h8000_0000_0000_0001, 64'hDEAD_BEEF_CAFE_F00D,
        64'hDEAD_BEEF_CAFE_F00D, 64'h1122_3344_5566_7788,
        64'h1122_3344_5566_7788, 64'hA5A5_A5A5_A5A5_A5A5};
    localparam logic [7:0] T_BAD [NV] = '{8'h00, 8'h00, 8'h01, 8'h80, 8'h01,
                                          8'hFF, 8'h10, 8'h3C, 8'h3C, 8'hFF};
    localparam logic [7:0] T_BE  [NV] = '{8'hFF, 8'hFF, 8'hFF, 8'h80, 8'h80,
                                          8'h00, 8'h10, 8'hC3, 8'h04, 8'hFF};
    localparam logic       T_RDY [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                          1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

    logic        clk = 1'b0;
    logic        rst_n, wr_cycle, rd_cycle, rdy;
    logic [7:0]  byte_en, bus_pin, bus_pout;
    logic [63:0] core_wdata, bus_din, bus_dout, rd_data;
    logic        bus_oe, rd_strobe, par_err;
    int          n_chk = 0;
    int          n_err = 0;
    logic [63:0] last_rd;

    always #(CLK_P/2) clk = ~clk;

    lane_parity_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_cycle(wr_cycle), .rd_cycle(rd_cycle),
        .rdy(rdy), .byte_en(byte_en), .core_wdata(core_wdata),
        .bus_din(bus_din), .bus_pin(bus_pin), .bus_dout(bus_dout),
        .bus_pout(bus_pout), .bus_oe(bus_oe), .rd_data(rd_data),
        .rd_strobe(rd_strobe), .par_err(par_err)
    );

    // Even parity by counting ones per byte.
    function automatic logic [7:0] ref_par(input logic [63:0] d);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) begin
            int ones = 0;
            for (int b = 0; b < 8; b++) ones += int'(d[i*8 + b]);
            p[i] = (ones % 2) != 0;
        end
        return p;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle;
        wr_cycle = 0; rd_cycle = 0; rdy = 0;
    endtask

    initial begin
        #(CLK_P * 20000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; idle(); byte_en = 0; core_wdata = 0;
        bus_din = 0; bus_pin = 0;
        @(negedge clk); step();
        chk("R1 par_err after reset", par_err, 0);
        chk("R1 bus_oe after reset", bus_oe, 0);
        chk("R1 rd_strobe after reset", rd_strobe, 0);
        chk("R1 rd_data after reset", rd_data, 0);
        chk("R1 bus_dout after reset", bus_dout, 0);
        rst_n = 1; step();

        // Table walk of read samples.
        last_rd = 64'h0;
        for (int v = 0; v < NV; v++) begin
            logic expf;
            rd_cycle = 1; rdy = T_RDY[v]; byte_en = T_BE[v];
            bus_din = T_DATA[v];
            bus_pin = ref_par(T_DATA[v]) ^ T_BAD[v];
            expf = T_RDY[v] && ((T_BAD[v] & T_BE[v]) != 0);
            if (T_RDY[v]) last_rd = T_DATA[v];
            step();
            chk($sformatf("R6/R7 flag vector %0d", v), par_err, expf);
            chk($sformatf("R5 rd_data vector %0d", v), rd_data, last_rd);
            chk($sformatf("R5 strobe vector %0d", v), rd_strobe, T_RDY[v]);
        end

        // Failing sample then idle: flag lasts one clock.
        rd_cycle = 1; rdy = 1; byte_en = 8'hFF;
        bus_din = 64'h55; bus_pin = ref_par(64'h55) ^ 8'h01;
        step();
        chk("R6 flag on failing sample", par_err, 1);
        idle(); step();
        chk("R6 flag one clock only", par_err, 0);
        chk("R8 idle bad parity no flag", par_err, 0);

        // Bad parity while writing, and with both cycle lines high.
        wr_cycle = 1; rdy = 1; core_wdata = 64'h0102_0408_1020_4080;
        chk("R3 oe low on first write clock", bus_oe, 0);
        step();
        chk("R8 no flag during write", par_err, 0);
        chk("R3 oe high second clock", bus_oe, 1);
        chk("R4 dout first beat", bus_dout, 64'h0102_0408_1020_4080);
        chk("R2 pout first beat", bus_pout, ref_par(64'h0102_0408_1020_4080));
        rd_cycle = 1; core_wdata = 64'hF0E1_D2C3_B4A5_9687;
        step();
        chk("R8 no flag rd and wr both high", par_err, 0);
        chk("R5 no sample when write high", rd_data, 64'h55);
        chk("R4 dout tracks", bus_dout, 64'hF0E1_D2C3_B4A5_9687);
        chk("R2 pout tracks", bus_pout, ref_par(64'hF0E1_D2C3_B4A5_9687));
        rd_cycle = 0; core_wdata = 64'h8000_0000_0000_0000;
        step();
        chk("R2 top lane parity", bus_pout, 8'h80);
        wr_cycle = 0; rdy = 0; core_wdata = 64'h1;
        step();
        chk("R3 oe falls after cycle ends", bus_oe, 0);
        chk("R4 dout holds when idle", bus_dout, 64'h8000_0000_0000_0000);

        // Ready low with bad parity on every lane.
        rd_cycle = 1; rdy = 0; byte_en = 8'hFF; bus_pin = ~ref_par(bus_din);
        step();
        chk("R8 no flag while rdy low", par_err, 0);

        // Reset clears a raised flag.
        rdy = 1; step();
        chk("R6 flag set before reset", par_err, 1);
        rst_n = 0; idle(); step();
        chk("R1 reset clears flag", par_err, 0);
        rst_n = 1; step();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule